// File: doc/BRIEF.md
# ADC Conversion Sequencing Controller

This block is the digital sequencer that sits in front of a multi-channel successive-approximation converter. It waits for a start condition, picks the channel for each conversion, issues a one-cycle start strobe to the analog core, and waits for the core's end-of-conversion input. When the last channel of the sequence is done, it raises a one-cycle end-of-sequence flag. A sequence can be started in three ways: by a software request, by a rising edge on one of six hardware trigger lines, or by free-run mode, which restarts the sequence as soon as it finishes.

The channel order comes from one of two sources. In scan mode the enabled channels are visited in ascending index order. In list mode a table of sixteen 4-bit slots is walked from slot 0 to a programmed final slot, and a channel may appear in more than one slot. The controller also gates power to the core and to the reference between sequences. It waits a coded startup time after leaving the powered-down state. When per-channel analog settings are in use and the setting changes from one conversion to the next, it waits a coded settling time before the conversion.

Top module: `adc_seq_ctrl`

## Requirements
- R1: In idle, `sw_start` high at a rising edge starts a sequence, and `soc` is high in the second cycle after that edge. With `hw_trig_en` high, a rising edge on `trig_in[trig_sel]` (select values 0 to 5; values 6 and 7 pick no line) passes through a 2-flop synchronizer and an edge detector, so `soc` rises 4 cycles after the input changes. An edge on a line that is not selected has no effect.
- R2: With `hw_trig_en` low, edges on `trig_in` start nothing.
- R3: With `free_run` high, sequences restart back to back with no start request, and each sequence completes in full.
- R4: A start request or trigger edge that arrives while `busy` is high is dropped. It is neither queued nor does it restart the sequence.
- R5: With `use_list` low, each channel whose bit is set in `ch_enable` is converted once, in ascending index order. With `ch_enable` zero, no sequence starts.
- R6: With `use_list` high, slot k is `seq_list[4k+3:4k]`. Slots 0 to `seq_last` are converted in slot order, repeated channels included, and `ch_enable` is ignored.
- R7: `soc` and `eos` are one-cycle pulses. `eos` rises in the cycle after the edge that samples `eoc` for the last conversion, and a sequence produces exactly one `eos`.
- R8: With `sleep_mode` low, `core_en` and `ref_en` are always high.
- R9: With `sleep_mode` high, `core_en` is low while idle. `ref_en` is also low while idle when `fast_wake` is low, and stays high when `fast_wake` is high. Both are high for every conversion.
- R10: With `sleep_mode` high, leaving idle inserts a wait selected by `startup_code` of 0, 8, 16, 24, 64, 80, 96, 112, 512, 576, 640, 704, 768, 832, 896 or 960 cycles for codes 0 to 15. With `sleep_mode` low, no wait is inserted.
- R11: A settling wait of 3, 5, 9 or 17 cycles (codes 0 to 3 of `settle_code`) is inserted before a conversion only when `per_ch_cfg` is high and `cfg_out` differs from the setting of the previous conversion. That setting is 0 after reset. The gap from one `soc` to the next equals the bench's end-of-conversion turnaround plus this wait.
- R12: `cfg_out` equals `shared_cfg` when `per_ch_cfg` is low, and equals `ch_cfg[3c+2:3c]` for the current channel c when it is high.
- R13: After reset, `soc`, `eos` and `busy` are low, `ch_sel` is 0, and the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_start | input | 1 | Software start request |
| hw_trig_en | input | 1 | Enables hardware trigger starts |
| trig_sel | input | 3 | Hardware trigger line select |
| trig_in | input | 6 | Asynchronous hardware trigger lines |
| free_run | input | 1 | Restart continuously without triggers |
| sleep_mode | input | 1 | Power down between sequences |
| fast_wake | input | 1 | Keep the reference on while asleep |
| startup_code | input | 4 | Coded wake-up wait |
| settle_code | input | 2 | Coded settling wait |
| per_ch_cfg | input | 1 | Use per-channel analog settings |
| shared_cfg | input | 3 | Analog setting shared by all channels |
| ch_cfg | input | 48 | Per-channel analog settings, 3 bits each |
| use_list | input | 1 | Take the order from the slot list |
| ch_enable | input | 16 | Channels converted in scan mode |
| seq_list | input | 64 | Sixteen 4-bit channel slots |
| seq_last | input | 4 | Index of the final slot |
| eoc | input | 1 | End of conversion from the analog core |
| soc | output | 1 | Start-of-conversion strobe |
| eos | output | 1 | End-of-sequence pulse |
| busy | output | 1 | Sequence in progress |
| ch_sel | output | 4 | Channel being converted |
| cfg_out | output | 3 | Analog setting for the current channel |
| core_en | output | 1 | ADC core power enable |
| ref_en | output | 1 | Reference power enable |

## Verification
The hardest case to reach is the settling decision, because it depends on the setting of the previous conversion and that setting never appears at a port. The stimulus therefore runs sequences in a fixed order. Earlier runs with per-channel settings off and a zero shared setting leave the remembered setting at 0. A later run then sets mismatching settings on chosen neighbouring channels, and each gap between successive strobes is measured against the turnaround plus the coded wait. A final run with a non-zero shared setting and per-channel settings off shows that a changed setting inserts no wait in that mode.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NCH   = 16,
  parameter int SLOTS = 16,
  parameter int CFG_W = 3,
  parameter int NTRIG = 6,
  parameter int CNT_W = 10,
  localparam int CH_W = $clog2(NCH),
  localparam int SL_W = $clog2(SLOTS)
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sw_start,
  input  logic                   hw_trig_en,
  input  logic [2:0]             trig_sel,
  input  logic [NTRIG-1:0]       trig_in,
  input  logic                   free_run,
  input  logic                   sleep_mode,
  input  logic                   fast_wake,
  input  logic [3:0]             startup_code,
  input  logic [1:0]             settle_code,
  input  logic                   per_ch_cfg,
  input  logic [CFG_W-1:0]       shared_cfg,
  input  logic [NCH*CFG_W-1:0]   ch_cfg,
  input  logic                   use_list,
  input  logic [NCH-1:0]         ch_enable,
  input  logic [SLOTS*CH_W-1:0]  seq_list,
  input  logic [SL_W-1:0]        seq_last,
  input  logic                   eoc,
  output logic                   soc,
  output logic                   eos,
  output logic                   busy,
  output logic [CH_W-1:0]        ch_sel,
  output logic [CFG_W-1:0]       cfg_out,
  output logic                   core_en,
  output logic                   ref_en
);

  typedef enum logic [2:0] {IDLE, WAKE, PREP, SETTLE, CONV, WAIT} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [CH_W-1:0]  cur;
  logic [SL_W-1:0]  slot;
  logic [CFG_W-1:0] last_cfg;
  logic [2:0]       sync;
  logic             eos_q;

  function automatic logic [CH_W:0] scan(input logic [NCH-1:0] en, input int from);
    logic [CH_W:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (en[i] && i >= from) r = {1'b1, i[CH_W-1:0]};
    return r;
  endfunction

  function automatic int wake_len(input logic [3:0] c);
    if (c < 4'd4)      return int'(c) * 8;
    else if (c < 4'd8) return 64 + (int'(c) - 4) * 16;
    else               return 512 + (int'(c) - 8) * 64;
  endfunction

  logic [7:0]       trig_pad;
  logic             hw_edge, start_req, has_work, is_last, need_settle;
  logic [CH_W:0]    first_num, next_num;
  logic [CH_W-1:0]  list_first, list_next;
  logic [SL_W-1:0]  slot_nx;
  logic [CNT_W-1:0] wake_n, settle_n;

  assign trig_pad    = 8'(trig_in);
  assign hw_edge     = sync[1] & ~sync[2];
  assign start_req   = sw_start | (hw_trig_en & hw_edge) | free_run;
  assign first_num   = scan(ch_enable, 0);
  assign next_num    = scan(ch_enable, int'(cur) + 1);
  assign slot_nx     = slot + 1'b1;
  assign list_first  = seq_list[CH_W-1:0];
  assign list_next   = seq_list[int'(slot_nx)*CH_W +: CH_W];
  assign has_work    = use_list | first_num[CH_W];
  assign is_last     = use_list ? (slot == seq_last) : !next_num[CH_W];
  assign wake_n      = CNT_W'(wake_len(startup_code));
  assign settle_n    = CNT_W'((1 << (int'(settle_code) + 1)) + 1);
  assign cfg_out     = per_ch_cfg ? ch_cfg[int'(cur)*CFG_W +: CFG_W] : shared_cfg;
  assign need_settle = per_ch_cfg && (cfg_out != last_cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      cur      <= '0;
      slot     <= '0;
      last_cfg <= '0;
      sync     <= '0;
      eos_q    <= 1'b0;
    end else begin
      sync  <= {sync[1:0], (int'(trig_sel) < NTRIG) ? trig_pad[trig_sel] : 1'b0};
      eos_q <= 1'b0;
      case (st)
        IDLE: if (start_req && has_work) begin
          slot <= '0;
          cur  <= use_list ? list_first : first_num[CH_W-1:0];
          if (sleep_mode && wake_n != '0) begin
            cnt <= wake_n - 1'b1;
            st  <= WAKE;
          end else st <= PREP;
        end
        WAKE: if (cnt == '0) st <= PREP; else cnt <= cnt - 1'b1;
        PREP: if (need_settle) begin
          cnt <= settle_n - 1'b1;
          st  <= SETTLE;
        end else st <= CONV;
        SETTLE: if (cnt == '0) st <= CONV; else cnt <= cnt - 1'b1;
        CONV: begin
          last_cfg <= cfg_out;
          st       <= WAIT;
        end
        WAIT: if (eoc) begin
          if (is_last) begin
            eos_q <= 1'b1;
            st    <= IDLE;
          end else begin
            slot <= slot_nx;
            cur  <= use_list ? list_next : next_num[CH_W-1:0];
            st   <= PREP;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign soc     = (st == CONV);
  assign eos     = eos_q;
  assign busy    = (st != IDLE);
  assign ch_sel  = cur;
  assign core_en = !sleep_mode || busy;
  assign ref_en  = !sleep_mode || fast_wake || busy;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int NCH = 16,
  localparam int CH_W = $clog2(NCH)
)(
  input logic            clk,
  input logic            rst_n,
  input logic            soc,
  input logic            eos,
  input logic            eoc,
  input logic            core_en,
  input logic            ref_en,
  input logic            sleep_mode,
  input logic            fast_wake,
  input logic            use_list,
  input logic [NCH-1:0]  ch_enable,
  input logic [CH_W-1:0] ch_sel
);

  assert_soc_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n) soc |=> !soc);
  assert_eos_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n) eos |=> !eos);
  assert_eos_after_eoc_R7: assert property (@(posedge clk) disable iff (!rst_n) eos |-> $past(eoc));
  assert_powered_conv_R9: assert property (@(posedge clk) disable iff (!rst_n) soc |-> (core_en && ref_en));
  assert_ref_kept_R9: assert property (@(posedge clk) disable iff (!rst_n) (sleep_mode && fast_wake) |-> ref_en);
  assert_awake_normal_R8: assert property (@(posedge clk) disable iff (!rst_n) !sleep_mode |-> (core_en && ref_en));
  assert_enabled_only_R5: assert property (@(posedge clk) disable iff (!rst_n) (soc && !use_list) |-> ch_enable[ch_sel]);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .soc(soc), .eos(eos), .eoc(eoc),
  .core_en(core_en), .ref_en(ref_en), .sleep_mode(sleep_mode),
  .fast_wake(fast_wake), .use_list(use_list), .ch_enable(ch_enable),
  .ch_sel(ch_sel)
);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_start = 0, hw_trig_en = 0, free_run = 0;
  logic [2:0]  trig_sel = 0;
  logic [5:0]  trig_in = 0;
  logic        sleep_mode = 0, fast_wake = 0, per_ch_cfg = 0, use_list = 0;
  logic [3:0]  startup_code = 0;
  logic [1:0]  settle_code = 0;
  logic [2:0]  shared_cfg = 0;
  logic [47:0] ch_cfg = 0;
  logic [15:0] ch_enable = 0;
  logic [63:0] seq_list = 0;
  logic [3:0]  seq_last = 0;
  logic        eoc = 0;
  logic        soc, eos, busy, core_en, ref_en;
  logic [3:0]  ch_sel;
  logic [2:0]  cfg_out;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .hw_trig_en(hw_trig_en),
    .trig_sel(trig_sel), .trig_in(trig_in), .free_run(free_run),
    .sleep_mode(sleep_mode), .fast_wake(fast_wake), .startup_code(startup_code),
    .settle_code(settle_code), .per_ch_cfg(per_ch_cfg), .shared_cfg(shared_cfg),
    .ch_cfg(ch_cfg), .use_list(use_list), .ch_enable(ch_enable),
    .seq_list(seq_list), .seq_last(seq_last), .eoc(eoc), .soc(soc), .eos(eos),
    .busy(busy), .ch_sel(ch_sel), .cfg_out(cfg_out), .core_en(core_en),
    .ref_en(ref_en)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int nsoc = 0, neos = 0;
  int log_ch [256];
  int log_t  [256];
  int log_cfg[256];
  int log_pw [256];
  int base, ebase, t_start;

  initial forever begin
    @(negedge clk);
    if (soc && nsoc < 256) begin
      log_ch[nsoc]  = int'(ch_sel);
      log_t[nsoc]   = cyc;
      log_cfg[nsoc] = int'(cfg_out);
      log_pw[nsoc]  = int'(core_en && ref_en);
      nsoc++;
    end
  end

  initial forever begin
    @(negedge clk);
    if (eos) neos++;
  end

  initial forever begin
    @(negedge clk);
    eoc = 1'b0;
    if (soc) begin
      repeat (2) @(negedge clk);
      eoc = 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog actual hung expected sequence completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic mark();
    base = nsoc; ebase = neos; t_start = cyc;
  endtask

  task automatic kick_sw();
    @(negedge clk);
    mark();
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (neos == ebase && k < 5000) begin
      @(negedge clk);
      k++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {ch_enable, conversions, first channel, last channel}
  localparam logic [28:0] VEC [5] = '{
    {16'h0001, 5'd1, 4'd0, 4'd0},
    {16'h8001, 5'd2, 4'd0, 4'd15},
    {16'hA5A5, 5'd8, 4'd0, 4'd15},
    {16'h0F00, 5'd4, 4'd8, 4'd11},
    {16'h4010, 5'd2, 4'd4, 4'd14}
  };

  int exp_list[5] = '{3, 3, 7, 1, 3};

  initial begin
    ch_cfg[5:3] = 3'd5;
    ch_cfg[8:6] = 3'd5;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13", "soc", int'(soc), 0);
    chk("R13", "eos", int'(eos), 0);
    chk("R13", "busy", int'(busy), 0);
    chk("R13", "ch_sel", int'(ch_sel), 0);
    rst_n = 1'b1;
    idle(2);
    chk("R13", "busy after release", int'(busy), 0);
    chk("R8", "core_en normal idle", int'(core_en), 1);
    chk("R8", "ref_en normal idle", int'(ref_en), 1);

    // R5 scan order vectors, R1 software latency, R7 one eos each
    for (int v = 0; v < 5; v++) begin
      int ok;
      ch_enable = VEC[v][28:13];
      kick_sw();
      wait_done();
      chk("R5", "conversions", nsoc - base, int'(VEC[v][12:8]));
      chk("R5", "first channel", log_ch[base], int'(VEC[v][7:4]));
      chk("R5", "last channel", log_ch[nsoc-1], int'(VEC[v][3:0]));
      ok = 1;
      for (int i = base + 1; i < nsoc; i++)
        if (log_ch[i] <= log_ch[i-1] || !ch_enable[log_ch[i]]) ok = 0;
      chk("R5", "ascending enabled order", ok, 1);
      chk("R1", "software start latency", log_t[base] - t_start, 2);
      chk("R7", "eos count", neos - ebase, 1);
    end

    // R5 nothing enabled
    ch_enable = 16'h0000;
    kick_sw();
    idle(20);
    chk("R5", "no conversion with empty enable", nsoc - base, 0);
    chk("R5", "busy with empty enable", int'(busy), 0);

    // R6 list order with repeats, enables ignored
    use_list = 1'b1;
    seq_list = '1;
    seq_list[3:0] = 4'd3; seq_list[7:4] = 4'd3; seq_list[11:8] = 4'd7;
    seq_list[15:12] = 4'd1; seq_list[19:16] = 4'd3;
    seq_last = 4'd4;
    kick_sw();
    wait_done();
    chk("R6", "list conversions", nsoc - base, 5);
    for (int i = 0; i < 5; i++) chk("R6", "list slot channel", log_ch[base+i], exp_list[i]);
    chk("R7", "list eos count", neos - ebase, 1);
    seq_last = 4'd0;
    kick_sw();
    wait_done();
    chk("R6", "single slot conversions", nsoc - base, 1);
    chk("R6", "single slot channel", log_ch[base], 3);
    use_list = 1'b0;

    // R1 hardware trigger on the selected line
    ch_enable = 16'h0001;
    hw_trig_en = 1'b1;
    trig_sel = 3'd2;
    idle(4);
    @(negedge clk);
    mark();
    trig_in[2] = 1'b1;
    wait_done();
    chk("R1", "hw trigger conversions", nsoc - base, 1);
    chk("R1", "hw trigger latency", log_t[base] - t_start, 4);
    trig_in = '0;
    idle(6);
    mark();
    trig_in[3] = 1'b1;
    idle(20);
    chk("R1", "unselected line ignored", nsoc - base, 0);
    trig_in = '0;
    idle(6);
    // R2 triggers disabled
    hw_trig_en = 1'b0;
    mark();
    trig_in[2] = 1'b1;
    idle(20);
    chk("R2", "disabled trigger ignored", nsoc - base, 0);
    trig_in = '0;
    idle(6);
    hw_trig_en = 1'b1;
    trig_sel = 3'd5;
    idle(4);
    @(negedge clk);
    mark();
    trig_in[5] = 1'b1;
    wait_done();
    chk("R1", "line 5 trigger conversions", nsoc - base, 1);
    trig_in = '0;
    hw_trig_en = 1'b0;
    idle(6);

    // R4 start during a running sequence is dropped
    ch_enable = 16'h0007;
    kick_sw();
    while (nsoc == base) @(negedge clk);
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    wait_done();
    idle(30);
    chk("R4", "conversions with extra start", nsoc - base, 3);
    chk("R4", "eos with extra start", neos - ebase, 1);

    // R3 free run
    ch_enable = 16'h0003;
    @(negedge clk);
    mark();
    free_run = 1'b1;
    begin
      int k = 0;
      while (neos - ebase < 3 && k < 5000) begin @(negedge clk); k++; end
    end
    free_run = 1'b0;
    begin
      int k = 0;
      while (busy && k < 5000) begin @(negedge clk); k++; end
    end
    idle(20);
    chk("R3", "free run repeated sequences", int'(neos - ebase >= 3), 1);
    chk("R3", "free run whole sequences", nsoc - base, 2 * (neos - ebase));
    chk("R3", "stops after free run off", int'(busy), 0);

    // R9 sleep power gating
    sleep_mode = 1'b1;
    idle(2);
    chk("R9", "core_en asleep", int'(core_en), 0);
    chk("R9", "ref_en asleep", int'(ref_en), 0);
    kick_sw();
    wait_done();
    chk("R9", "powered at conversions", log_pw[base] + log_pw[base+1], 2);
    chk("R9", "core_en asleep after run", int'(core_en), 0);
    fast_wake = 1'b1;
    idle(2);
    chk("R9", "core_en fast wake idle", int'(core_en), 0);
    chk("R9", "ref_en fast wake idle", int'(ref_en), 1);

    // R10 startup waits
    ch_enable = 16'h0001;
    fast_wake = 1'b0;
    startup_code = 4'd1;
    kick_sw(); wait_done();
    chk("R10", "startup code 1", log_t[base] - t_start, 10);
    startup_code = 4'd5;
    kick_sw(); wait_done();
    chk("R10", "startup code 5", log_t[base] - t_start, 82);
    startup_code = 4'd9;
    kick_sw(); wait_done();
    chk("R10", "startup code 9", log_t[base] - t_start, 578);
    fast_wake = 1'b1;
    startup_code = 4'd2;
    kick_sw(); wait_done();
    chk("R10", "startup code 2 fast wake", log_t[base] - t_start, 18);
    sleep_mode = 1'b0;
    fast_wake = 1'b0;
    startup_code = 4'd5;
    kick_sw(); wait_done();
    chk("R10", "no startup in normal power", log_t[base] - t_start, 2);
    startup_code = 4'd0;

    // R11 settling on changed per-channel setting; R12 setting output
    ch_enable = 16'h0007;
    per_ch_cfg = 1'b1;
    settle_code = 2'd2;
    kick_sw(); wait_done();
    chk("R11", "same setting no settle", log_t[base] - t_start, 2);
    chk("R11", "changed setting gap", log_t[base+1] - log_t[base], 13);
    chk("R11", "repeated setting gap", log_t[base+2] - log_t[base+1], 4);
    chk("R12", "per-channel setting ch1", log_cfg[base+1], 5);
    chk("R12", "per-channel setting ch0", log_cfg[base], 0);
    per_ch_cfg = 1'b0;
    kick_sw(); wait_done();
    chk("R11", "shared mode first latency", log_t[base] - t_start, 2);
    chk("R11", "shared mode gap", log_t[base+1] - log_t[base], 4);
    chk("R12", "shared setting used", log_cfg[base+1], 0);
    per_ch_cfg = 1'b1;
    settle_code = 2'd3;
    kick_sw(); wait_done();
    chk("R11", "settle code 3 gap", log_t[base+1] - log_t[base], 21);
    settle_code = 2'd0;
    kick_sw(); wait_done();
    chk("R11", "settle code 0 first", log_t[base] - t_start, 2 + 3);
    chk("R11", "settle code 0 gap", log_t[base+1] - log_t[base], 7);
    per_ch_cfg = 1'b0;
    shared_cfg = 3'd6;
    ch_enable = 16'h0002;
    kick_sw(); wait_done();
    chk("R12", "shared setting value", log_cfg[base], 6);
    chk("R11", "no settle when per-channel off", log_t[base] - t_start, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule